// File: doc/BRIEF.md
# SPI EEPROM Host Write Sequencer

This block sits on the host side of a small serial EEPROM with a 9-bit byte address. A client asks for one operation at a time over a simple command port. Five operations exist: power-up check, sequential read, single-byte write, full-page write and protection-level update. The sequencer turns each request into the instruction stream the EEPROM expects and hands it one byte at a time to an external SPI byte engine. It frames every transaction with a chip-select signal and collects the bytes that come back.

Address bit 8 does not travel in the address byte. It is folded into bit 3 of the read or write instruction. Every write-type operation is preceded by its own write-enable transaction. After programming, the sequencer lets a fixed settling time pass, counted in ticks of a millisecond strobe. It then polls the status byte until the busy flag clears. A single-byte write first reads back the stored byte and stops early when nothing would change. Page data is loaded into a 16-entry buffer through a fill port before the page command is issued.

Top module: `eeprom_wr_seq`

## Requirements
- R1: A read of N bytes (N from 1 to 255) is one chip-select window: instruction 0x03 with bit 3 equal to address bit 8, then the low 8 address bits, then N clocked-in bytes. Each returned byte appears once on rd_byte with rd_valid, in address order.
- R2: A byte write first runs a 3-byte read of the target address. If the stored byte equals the new data, the command ends with done and no further transaction.
- R3: A byte write that changes data issues a 1-byte transaction 0x06, then a separate 3-byte transaction: 0x02 (bit 3 = address bit 8), low address byte, data.
- R4: After any program transaction, at least 5 ms ticks pass before the first status read (0x05, status returned in the second byte, busy = bit 0). While busy is set, at least 1 tick passes before each further status read. done follows the first read with busy clear.
- R5: A page command (op 3) whose address is not a multiple of 16 ends with err and code 1, with no SPI traffic. One whose length is not 16 ends with code 2. Otherwise it sends 0x06, then one 18-byte transaction (opcode, low address, buffer entries 0 to 15).
- R6: A protection command (op 4) sends 0x06, then the 2-byte transaction 0x01 with the 2-bit level from cmd_wdata[1:0] placed in bits 3:2. The R4 completion sequence follows.
- R7: Init (op 0) waits at least 1 tick and then reads status once. If busy is set it ends with err and code 3, otherwise with done.
- R8: When POLL_MAX consecutive status reads after programming all show busy, the command ends with err and code 4.
- R9: busy is high from acceptance until the single-cycle done or err pulse. done and err never coincide, and a request made while busy is ignored.
- R10: A read (op 1) with length 0 ends with err and code 2 and no SPI traffic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when not busy |
| cmd_op | input | 3 | 0 init, 1 read, 2 byte write, 3 page write, 4 protection |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_len | input | LEN_W | Byte count for read and page write |
| cmd_wdata | input | 8 | Byte-write data; bits 1:0 give the protection level |
| fill_we | input | 1 | Page buffer write strobe |
| fill_idx | input | log2(PAGE_BYTES) | Page buffer entry |
| fill_byte | input | 8 | Page buffer data |
| ms_tick | input | 1 | One-cycle strobe per millisecond |
| spi_cs | output | 1 | Chip select, high for a whole transaction |
| spi_start | output | 1 | Start one byte exchange |
| spi_tx | output | 8 | Byte to shift out |
| spi_done | input | 1 | Byte exchange finished |
| spi_rx | input | 8 | Byte shifted in |
| busy | output | 1 | Command in progress |
| done | output | 1 | Success pulse |
| err | output | 1 | Failure pulse |
| err_code | output | 3 | 1 address, 2 length, 3 not ready, 4 timeout |
| rd_valid | output | 1 | rd_byte holds a read byte |
| rd_byte | output | 8 | Read data |

## Verification
Two things can meet in one cycle: a new request from the client and a command that is still in flight, most often during the long tick-counted wait after programming. The bench raises a read request in the middle of a byte write. It then judges the outcome at the ports: the transaction log must hold only the write's own sequence, no rd_valid byte may appear, and exactly one done pulse may close the write. The same log also shows whether a status read starts before the required number of millisecond ticks has elapsed.

// File: rtl/eew_pkg.sv
package eew_pkg;
  typedef enum logic [2:0] {
    OP_INIT = 3'd0, OP_READ = 3'd1, OP_WBYTE = 3'd2, OP_PAGE = 3'd3, OP_PROT = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    ERR_NONE = 3'd0, ERR_ADDR = 3'd1, ERR_LEN = 3'd2, ERR_NRDY = 3'd3, ERR_TMO = 3'd4
  } err_e;

  typedef enum logic [2:0] {
    T_RDSR, T_READ, T_PEEK, T_WREN, T_WRITE, T_PAGE, T_WRSR
  } txn_e;

  localparam logic [7:0] INS_READ  = 8'h03;
  localparam logic [7:0] INS_WRITE = 8'h02;
  localparam logic [7:0] INS_WREN  = 8'h06;
  localparam logic [7:0] INS_RDSR  = 8'h05;
  localparam logic [7:0] INS_WRSR  = 8'h01;
  localparam int HI_ADDR_POS = 3;
endpackage

// File: rtl/eew_page_buf.sv
module eew_page_buf #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eew_ms_timer.sv
module eew_ms_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      armed   <= 1'b0;
      expired <= 1'b0;
    end else if (load) begin
      cnt     <= load_val;
      armed   <= (load_val != '0);
      expired <= (load_val == '0);
    end else if (armed && tick) begin
      cnt <= cnt - 1'b1;
      if (cnt == CNT_W'(1)) begin
        armed   <= 1'b0;
        expired <= 1'b1;
      end
    end
  end

  // expiry only follows a millisecond strobe (or a zero-length load)
  assert_expire_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(expired) |-> ($past(tick) || $past(load)));
endmodule

// File: rtl/eeprom_wr_seq.sv
module eeprom_wr_seq
  import eew_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int LEN_W      = 8,
  parameter int PAGE_BYTES = 16,
  parameter int PROG_MS    = 5,
  parameter int POLL_MS    = 1,
  parameter int INIT_MS    = 1,
  parameter int POLL_MAX   = 64,
  parameter int TMR_W      = 8,
  localparam int PG_W      = $clog2(PAGE_BYTES),
  localparam int IDX_W     = LEN_W + 1,
  localparam int PC_W      = $clog2(POLL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [7:0]        cmd_wdata,
  input  logic              fill_we,
  input  logic [PG_W-1:0]   fill_idx,
  input  logic [7:0]        fill_byte,
  input  logic              ms_tick,
  output logic              spi_cs,
  output logic              spi_start,
  output logic [7:0]        spi_tx,
  input  logic              spi_done,
  input  logic [7:0]        spi_rx,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [2:0]        err_code,
  output logic              rd_valid,
  output logic [7:0]        rd_byte
);
  typedef enum logic [2:0] {S_IDLE, S_DELAY, S_OPEN, S_PREP, S_SEND, S_WAIT, S_NEXT} st_e;

  st_e               state;
  op_e               op_q;
  txn_e              kind;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [7:0]        wdata_q;
  logic [IDX_W-1:0]  idx, xlen, xlen_n;
  logic              stat_busy;
  logic [7:0]        peek_q;
  logic [PC_W-1:0]   poll_cnt;
  logic              tmr_load, tmr_exp;
  logic [TMR_W-1:0]  tmr_val;
  logic [PG_W-1:0]   buf_raddr;
  logic [7:0]        buf_q, tx_n, ins_n;

  assign buf_raddr = PG_W'(idx - IDX_W'(2));

  eew_page_buf #(.DEPTH(PAGE_BYTES), .W(8)) u_buf (
    .clk(clk), .we(fill_we), .waddr(fill_idx), .wdata(fill_byte),
    .raddr(buf_raddr), .rdata(buf_q));

  eew_ms_timer #(.CNT_W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .tick(ms_tick), .expired(tmr_exp));

  // byte to send for the current transaction position
  always_comb begin
    unique case (kind)
      T_RDSR:         ins_n = INS_RDSR;
      T_WREN:         ins_n = INS_WREN;
      T_WRSR:         ins_n = INS_WRSR;
      T_READ, T_PEEK: ins_n = INS_READ  | (8'(addr_q[ADDR_W-1]) << HI_ADDR_POS);
      default:        ins_n = INS_WRITE | (8'(addr_q[ADDR_W-1]) << HI_ADDR_POS);
    endcase
    if (idx == '0)                            tx_n = ins_n;
    else if (idx == IDX_W'(1))                tx_n = (kind == T_WRSR) ? {4'b0, wdata_q[1:0], 2'b0} :
                                                     (kind == T_RDSR) ? 8'h00 : addr_q[7:0];
    else if (kind == T_WRITE)                 tx_n = wdata_q;
    else if (kind == T_PAGE)                  tx_n = buf_q;
    else                                      tx_n = 8'h00;
    unique case (kind)
      T_WREN:               xlen_n = IDX_W'(1);
      T_RDSR, T_WRSR:       xlen_n = IDX_W'(2);
      T_PEEK, T_WRITE:      xlen_n = IDX_W'(3);
      T_PAGE:               xlen_n = IDX_W'(PAGE_BYTES + 2);
      default:              xlen_n = {1'b0, len_q} + IDX_W'(2);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; op_q <= OP_INIT; kind <= T_RDSR;
      addr_q <= '0; len_q <= '0; wdata_q <= '0;
      idx <= '0; xlen <= '0; stat_busy <= 1'b0; peek_q <= '0; poll_cnt <= '0;
      tmr_load <= 1'b0; tmr_val <= '0;
      spi_cs <= 1'b0; spi_start <= 1'b0; spi_tx <= '0;
      busy <= 1'b0; done <= 1'b0; err <= 1'b0; err_code <= ERR_NONE;
      rd_valid <= 1'b0; rd_byte <= '0;
    end else begin
      spi_start <= 1'b0; done <= 1'b0; err <= 1'b0;
      rd_valid <= 1'b0; tmr_load <= 1'b0;
      unique case (state)
        S_IDLE: if (cmd_valid) begin
          op_q <= op_e'(cmd_op); addr_q <= cmd_addr; len_q <= cmd_len;
          wdata_q <= cmd_wdata; poll_cnt <= '0; busy <= 1'b1;
          err_code <= ERR_NONE;
          unique case (cmd_op)
            OP_INIT: begin
              kind <= T_RDSR; tmr_load <= 1'b1; tmr_val <= TMR_W'(INIT_MS);
              state <= S_DELAY;
            end
            OP_READ: if (cmd_len == '0) begin
              busy <= 1'b0; err <= 1'b1; err_code <= ERR_LEN;
            end else begin
              kind <= T_READ; state <= S_OPEN;
            end
            OP_WBYTE: begin kind <= T_PEEK; state <= S_OPEN; end
            OP_PAGE: if (cmd_addr[PG_W-1:0] != '0) begin
              busy <= 1'b0; err <= 1'b1; err_code <= ERR_ADDR;
            end else if (cmd_len != LEN_W'(PAGE_BYTES)) begin
              busy <= 1'b0; err <= 1'b1; err_code <= ERR_LEN;
            end else begin
              kind <= T_WREN; state <= S_OPEN;
            end
            OP_PROT: begin kind <= T_WREN; state <= S_OPEN; end
            default: begin busy <= 1'b0; done <= 1'b1; end
          endcase
        end
        S_DELAY: if (!tmr_load && tmr_exp) state <= S_OPEN;
        S_OPEN: begin
          idx <= '0; xlen <= xlen_n; spi_cs <= 1'b1; state <= S_PREP;
        end
        S_PREP: state <= S_SEND;
        S_SEND: begin
          spi_start <= 1'b1; spi_tx <= tx_n; state <= S_WAIT;
        end
        S_WAIT: if (spi_done) begin
          if (kind == T_RDSR && idx == IDX_W'(1)) stat_busy <= spi_rx[0];
          if (kind == T_PEEK && idx == IDX_W'(2)) peek_q <= spi_rx;
          if (kind == T_READ && idx >= IDX_W'(2)) begin
            rd_valid <= 1'b1; rd_byte <= spi_rx;
          end
          if (idx == xlen - 1'b1) begin
            spi_cs <= 1'b0; state <= S_NEXT;
          end else begin
            idx <= idx + 1'b1; state <= S_PREP;
          end
        end
        S_NEXT: begin
          state <= S_IDLE;
          unique case (kind)
            T_RDSR: if (op_q == OP_INIT) begin
              busy <= 1'b0;
              if (stat_busy) begin err <= 1'b1; err_code <= ERR_NRDY; end
              else done <= 1'b1;
            end else if (!stat_busy) begin
              busy <= 1'b0; done <= 1'b1;
            end else if (poll_cnt == PC_W'(POLL_MAX - 1)) begin
              busy <= 1'b0; err <= 1'b1; err_code <= ERR_TMO;
            end else begin
              poll_cnt <= poll_cnt + 1'b1; tmr_load <= 1'b1;
              tmr_val <= TMR_W'(POLL_MS); state <= S_DELAY;
            end
            T_READ: begin busy <= 1'b0; done <= 1'b1; end
            T_PEEK: if (peek_q == wdata_q) begin
              busy <= 1'b0; done <= 1'b1;
            end else begin
              kind <= T_WREN; state <= S_OPEN;
            end
            T_WREN: begin
              kind  <= (op_q == OP_WBYTE) ? T_WRITE : (op_q == OP_PAGE) ? T_PAGE : T_WRSR;
              state <= S_OPEN;
            end
            default: begin
              kind <= T_RDSR; tmr_load <= 1'b1; tmr_val <= TMR_W'(PROG_MS);
              state <= S_DELAY;
            end
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_start_in_cs_R1: assert property (@(posedge clk) disable iff (rst)
    spi_start |-> spi_cs);
  assert_delay_needs_expiry_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_OPEN && $past(state) == S_DELAY) |-> $past(tmr_exp));
  assert_err_has_code_R5: assert property (@(posedge clk) disable iff (rst)
    err |-> (err_code != ERR_NONE));
  assert_poll_bound_R8: assert property (@(posedge clk) disable iff (rst)
    poll_cnt < PC_W'(POLL_MAX));
  assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  assert_finish_drops_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> !busy);
  assert_cmd_held_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(op_q) && $stable(addr_q));
endmodule

// File: tb/test_eeprom_wr_seq.sv
module test_eeprom_wr_seq;
  localparam int PMAX = 6;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0; logic [2:0] cmd_op = 0; logic [8:0] cmd_addr = 0;
  logic [7:0] cmd_len = 0, cmd_wdata = 0;
  logic fill_we = 0; logic [3:0] fill_idx = 0; logic [7:0] fill_byte = 0;
  logic ms_tick = 0, spi_done = 0; logic [7:0] spi_rx = 0;
  logic spi_cs, spi_start, busy, done, err, rd_valid;
  logic [7:0] spi_tx, rd_byte; logic [2:0] err_code;

  always #5 clk = ~clk;

  eeprom_wr_seq #(.POLL_MAX(PMAX)) i_eeprom_wr_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_wdata(cmd_wdata), .fill_we(fill_we), .fill_idx(fill_idx),
    .fill_byte(fill_byte), .ms_tick(ms_tick), .spi_cs(spi_cs), .spi_start(spi_start),
    .spi_tx(spi_tx), .spi_done(spi_done), .spi_rx(spi_rx), .busy(busy), .done(done),
    .err(err), .err_code(err_code), .rd_valid(rd_valid), .rd_byte(rd_byte));

  int n_chk = 0, n_bad = 0, cyc = 0;
  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // millisecond strobe every 10 cycles
  always @(negedge clk) begin
    cyc++;
    ms_tick <= (cyc % 10 == 0);
    if (cyc > 150000) begin
      chk("watchdog", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // EEPROM model behind an ideal byte engine
  logic [7:0] mem [512];
  logic wel = 0; logic [1:0] bp = 0; int busy_left = 0, prog_busy = 0;
  logic cs_prev = 0; int bidx = 0, ticks_since = 0, dly = 0;
  logic [7:0] topc = 0, rxq = 0; logic [8:0] taddr = 0; logic [7:0] wbuf [20];
  int nlog = 0; logic [7:0] log_op [64], log_b1 [64]; int log_len [64], log_tk [64];
  logic [7:0] rd_buf [16]; int rd_n = 0, n_done = 0;

  always @(negedge clk) begin
    logic [7:0] st;
    st = {4'b0, bp, wel, busy_left > 0};
    spi_done <= 0;
    if (dly > 0) begin
      dly--;
      if (dly == 0) begin spi_done <= 1; spi_rx <= rxq; end
    end
    if (ms_tick) ticks_since++;
    if (rd_valid && rd_n < 16) begin rd_buf[rd_n] = rd_byte; rd_n++; end
    if (done) n_done++;
    if (spi_cs && !cs_prev) begin bidx = 0; log_tk[nlog] = ticks_since; end
    if (spi_start) begin
      if (bidx == 0) begin topc = spi_tx; rxq = 0; end
      else begin
        if (bidx == 1) begin taddr = {topc[3], spi_tx}; log_b1[nlog] = spi_tx; end
        if ((topc & 8'hF7) == 8'h03 && bidx >= 2) rxq = mem[9'(taddr + 9'(bidx - 2))];
        else if (topc == 8'h05) rxq = st;
        else rxq = 0;
      end
      if (bidx < 20) wbuf[bidx] = spi_tx;
      bidx++; dly = 2;
    end
    if (!spi_cs && cs_prev) begin
      if (nlog < 64) begin log_op[nlog] = topc; log_len[nlog] = bidx; nlog++; end
      ticks_since = 0;
      if (topc == 8'h06) wel = 1;
      else if (topc == 8'h05) begin if (busy_left > 0) busy_left--; end
      else if (topc == 8'h01 && wel) begin bp = wbuf[1][3:2]; wel = 0; busy_left = prog_busy; end
      else if ((topc & 8'hF7) == 8'h02 && wel) begin
        for (int i = 2; i < bidx && i < 20; i++)
          mem[{taddr[8:4], 4'(taddr[3:0] + 4'(i - 2))}] = wbuf[i];
        wel = 0; busy_left = prog_busy;
      end
    end
    cs_prev = spi_cs;
  end

  int base, r_code; logic r_done, r_err;
  task automatic run_cmd(int op, int addr, int len, int wd);
    int w;
    base = nlog; rd_n = 0;
    @(negedge clk);
    cmd_valid = 1; cmd_op = 3'(op); cmd_addr = 9'(addr); cmd_len = 8'(len); cmd_wdata = 8'(wd);
    @(negedge clk);
    cmd_valid = 0;
    w = 0;
    while (!(done || err) && w < 20000) begin @(negedge clk); w++; end
    r_done = done; r_err = err; r_code = err_code;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R9 reset busy", busy, 0); chk("R9 reset cs", spi_cs, 0);
    chk("R9 reset done", done, 0);
  endtask

  task automatic t_init();
    run_cmd(0, 0, 0, 0);
    chk("R7 init done", r_done, 1); chk("R7 one status read", nlog - base, 1);
    chk("R7 status opcode", log_op[base], 8'h05);
    chk("R7 waited a tick", log_tk[base] >= 1, 1);
    busy_left = 1;
    run_cmd(0, 0, 0, 0);
    chk("R7 not ready err", r_err, 1); chk("R7 code", r_code, 3);
  endtask

  task automatic t_write_change();
    prog_busy = 2;
    run_cmd(2, 9'h1AB, 0, 8'hEF);
    chk("R3 done", r_done, 1);
    chk("R3 txn count", nlog - base, 6);
    chk("R3 peek op", log_op[base], 8'h0B);
    chk("R3 wren", log_op[base+1], 8'h06); chk("R3 wren len", log_len[base+1], 1);
    chk("R3 write op", log_op[base+2], 8'h0A); chk("R3 write len", log_len[base+2], 3);
    chk("R3 addr byte", log_b1[base+2], 8'hAB);
    chk("R3 stored", mem[9'h1AB], 8'hEF);
    chk("R4 prog wait", (log_tk[base+3] >= 5) && (log_tk[base+3] <= 6), 1);
    chk("R4 status op", log_op[base+5], 8'h05);
    chk("R4 poll gap", (log_tk[base+4] >= 1) && (log_tk[base+5] >= 1), 1);
  endtask

  task automatic t_read();
    mem[9'h1A9] = 8'h11; mem[9'h1AA] = 8'h22; mem[9'h1AC] = 8'h44;
    run_cmd(1, 9'h1A9, 4, 0);
    chk("R1 done", r_done, 1); chk("R1 one txn", nlog - base, 1);
    chk("R1 opcode", log_op[base], 8'h0B); chk("R1 length", log_len[base], 6);
    chk("R1 addr byte", log_b1[base], 8'hA9); chk("R1 count", rd_n, 4);
    chk("R1 b0", rd_buf[0], 8'h11); chk("R1 b2", rd_buf[2], 8'hEF);
    chk("R1 b3", rd_buf[3], 8'h44);
    mem[9'h05] = 8'h5A;
    run_cmd(1, 9'h05, 1, 0);
    chk("R1 low opcode", log_op[base], 8'h03); chk("R1 low data", rd_buf[0], 8'h5A);
  endtask

  task automatic t_write_same();
    run_cmd(2, 9'h1AB, 0, 8'hEF);
    chk("R2 done", r_done, 1); chk("R2 only peek", nlog - base, 1);
    chk("R2 peek len", log_len[base], 3);
  endtask

  task automatic t_page();
    run_cmd(3, 9'h105, 16, 0);
    chk("R5 unaligned err", r_err, 1); chk("R5 code addr", r_code, 1);
    chk("R5 no traffic", nlog - base, 0);
    run_cmd(3, 9'h100, 15, 0);
    chk("R5 code len", r_code, 2); chk("R5 no traffic len", nlog - base, 0);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); fill_we = 1; fill_idx = 4'(i); fill_byte = 8'(8'hA0 + i);
    end
    @(negedge clk); fill_we = 0;
    prog_busy = 0;
    run_cmd(3, 9'h100, 16, 0);
    chk("R5 page done", r_done, 1); chk("R5 wren", log_op[base], 8'h06);
    chk("R5 page op", log_op[base+1], 8'h0A); chk("R5 page len", log_len[base+1], 18);
    chk("R5 first", mem[9'h100], 8'hA0); chk("R5 last", mem[9'h10F], 8'hAF);
  endtask

  task automatic t_prot();
    run_cmd(4, 0, 0, 2);
    chk("R6 done", r_done, 1); chk("R6 wren", log_op[base], 8'h06);
    chk("R6 wrsr op", log_op[base+1], 8'h01); chk("R6 code byte", log_b1[base+1], 8'h08);
    chk("R6 wait", log_tk[base+2] >= 5, 1); chk("R6 model level", bp, 2);
  endtask

  task automatic t_timeout();
    prog_busy = 1000;
    run_cmd(4, 0, 0, 0);
    chk("R8 err", r_err, 1); chk("R8 code", r_code, 4);
    chk("R8 status reads", nlog - base - 2, PMAX);
    busy_left = 0; prog_busy = 0;
  endtask

  task automatic t_ignore();
    int d0;
    d0 = n_done;
    prog_busy = 1;
    fork
      run_cmd(2, 9'h33, 0, 8'h77);
      begin
        repeat (30) @(negedge clk);
        cmd_valid = 1; cmd_op = 3'd1; cmd_addr = 9'h0; cmd_len = 8'd1;
        @(negedge clk); cmd_valid = 0;
      end
    join
    chk("R9 single done", n_done - d0, 1);
    chk("R9 txns of write only", nlog - base, 5);
    chk("R9 no read data", rd_n, 0);
    run_cmd(1, 0, 0, 0);
    chk("R10 err", r_err, 1); chk("R10 code", r_code, 2);
    chk("R10 no traffic", nlog - base, 0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset(); t_init(); t_write_change(); t_read(); t_write_same();
    t_page(); t_prot(); t_timeout(); t_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule